// File: doc/BRIEF.md
# Boot Remap and Abort Address Decoder

This block turns each processor address into a single target: the on-chip SRAM, one of eight external chip selects, or the on-chip peripheral window. It also flags an abort when an address inside the external bus space reaches no chip select. Decoding is purely combinational from the address while the valid strobe is high. There is no handshake and no back-pressure: every presented address is decoded in the same cycle. A new address may be driven on any cycle.

While reset is held, the block watches the boot-mode pin through a synchroniser and a ten-stage shift register. At reset release it freezes the boot memory width, which stays fixed until the next reset. Out of reset, chip select 0 is also seen at address zero, so the processor fetches from external boot memory. A single write of 1 to the remap control bit moves the 8 KB SRAM to address zero and unlocks chip selects 1 to 7. That change is one-way, and only a reset undoes it.

Top module: `mem_map_decoder`

## Requirements
- R1: While `rst_n` is low, the block captures the level of `boot_pin` (held steady for at least 14 cycles). At release it holds `boot_narrow` at that level until the next reset: 1 means 8-bit boot memory, 0 means 16-bit. Later changes of the pin have no effect.
- R2: Before remap, addresses 0x0000_0000 to 0x000F_FFFF assert `cs[0]`, and addresses 0x0030_0000 to 0x0030_1FFF assert `sel_sram`. Other addresses below 0x0040_0000 assert nothing.
- R3: After remap, addresses 0x0000_0000 to 0x0000_1FFF assert `sel_sram`. Every other address below 0x0040_0000 asserts nothing, including the former boot alias and the former SRAM location.
- R4: A cycle with `ctl_wr` high and `ctl_wdata[0]` high sets remap from the next cycle on. A write with bit 0 low changes nothing, whether remap is set or not.
- R5: A low level on `rst_n` clears remap, so address 0 again selects `cs[0]`.
- R6: Before remap, the ranges of chip selects 1 to 7 assert no chip select and raise `abort`.
- R7: In the external space, chip select k (k = 0..7) owns 1 MB at 0x0100_0000·(k+1). A matching access asserts only `cs[k]`, before and after remap, subject to R6.
- R8: `abort` is high for a valid address in [0x0040_0000, 0xFFC0_0000) that hits no chip select. It is never high below 0x0040_0000 or at or above 0xFFC0_0000, where `sel_periph` is asserted.
- R9: With `addr_vld` low, `cs`, `sel_sram`, `sel_periph` and `abort` are all low.
- R10: At most one of `abort`, `sel_periph`, `sel_sram` and the `cs` bits is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; boot capture window closes at its release |
| boot_pin | input | 1 | Boot-mode strap pin, asynchronous |
| addr | input | 32 | Processor byte address |
| addr_vld | input | 1 | Address is valid this cycle |
| ctl_wr | input | 1 | Write strobe for the remap control register |
| ctl_wdata | input | 8 | Write data; bit 0 requests remap, other bits reserved |
| sel_sram | output | 1 | Access targets the on-chip SRAM |
| sel_periph | output | 1 | Access targets the peripheral window |
| cs | output | 8 | External chip selects, active high |
| boot_narrow | output | 1 | 1: 8-bit boot memory, 0: 16-bit |
| abort | output | 1 | Access to an undefined external address |

## Verification
The bench sweeps every megabyte of the address space at four offsets chosen to hit the edges of the SRAM, the boot alias and the chip-select windows. It runs the sweep once before remap and once after. A decoder that left the boot alias active after remap, or that left the SRAM at its old place, would select a second target at address zero. One that unlocked chip selects 1 to 7 too early would drop the aborts expected in their ranges. The bench also writes zero with remap both clear and set. A remap bit that is not sticky, or one set by any write, shows up at address zero. Two resets with opposite strap levels catch a boot width that is not frozen at release or not refreshed by reset.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
  localparam int ADDR_W = 32;

  typedef enum logic [1:0] {
    SPACE_INTERNAL = 2'd0,
    SPACE_EXTERNAL = 2'd1,
    SPACE_PERIPH   = 2'd2
  } space_e;

  function automatic space_e classify(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] ext_lo,
                                      input logic [ADDR_W-1:0] periph_lo);
    if (a >= periph_lo)   return SPACE_PERIPH;
    else if (a >= ext_lo) return SPACE_EXTERNAL;
    else                  return SPACE_INTERNAL;
  endfunction
endpackage

// File: rtl/mmd_boot_sampler.sv
module mmd_boot_sampler #(
  parameter int SYNC_STAGES = 2,
  parameter int WINDOW      = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic boot_narrow
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [WINDOW-1:0]      window_q;
  logic                   boot_q;

  // Free-running synchroniser and window; they must run while reset is low.
  always_ff @(posedge clk) begin
    sync_q   <= {sync_q[SYNC_STAGES-2:0], pin};
    window_q <= {window_q[WINDOW-2:0], sync_q[SYNC_STAGES-1]};
  end

  // The oldest sample of the window is taken while reset is held; frozen after release.
  always_ff @(posedge clk) begin
    if (!rst_n) boot_q <= window_q[WINDOW-1];
  end

  assign boot_narrow = boot_q;

  AST_BOOT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(boot_narrow)); // R1
endmodule

// File: rtl/mmd_remap_reg.sv
module mmd_remap_reg #(
  parameter int CTL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  output logic             remap
);
  logic remap_q;
  logic unused_wdata;

  assign unused_wdata = ^wdata[CTL_W-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                remap_q <= 1'b0;
    else if (wr && wdata[0])   remap_q <= 1'b1;
  end

  assign remap = remap_q;

  AST_REMAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    remap |=> remap); // R4
  AST_REMAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(remap) |-> $past(wr && wdata[0])); // R4
endmodule

// File: rtl/mmd_cs_match.sv
module mmd_cs_match #(
  parameter int                           NUM_CS       = 8,
  parameter logic [NUM_CS-1:0][31:0]      CS_BASE      = '0,
  parameter logic [NUM_CS-1:0][4:0]       CS_SIZE_LOG2 = '0,
  parameter logic [NUM_CS-1:0]            CS_ENABLE    = '1
) (
  input  logic [31:0]       addr,
  input  logic              in_ext,
  input  logic              remap,
  output logic [NUM_CS-1:0] hit
);
  logic [NUM_CS-1:0] raw;

  for (genvar k = 0; k < NUM_CS; k++) begin : g_cs
    localparam int SH = int'(CS_SIZE_LOG2[k]);
    logic window_hit;
    assign window_hit = ((addr >> SH) == (CS_BASE[k] >> SH));
    if (k == 0) begin : g_boot_cs
      assign raw[k] = CS_ENABLE[k] && in_ext && window_hit;
    end else begin : g_locked_cs
      assign raw[k] = CS_ENABLE[k] && in_ext && window_hit && remap;
    end
  end

  // Lowest index wins if windows overlap.
  always_comb hit = raw & (~raw + NUM_CS'(1));
endmodule

// File: rtl/mem_map_decoder.sv
module mem_map_decoder
  import mmd_pkg::*;
#(
  parameter int                      NUM_CS          = 8,
  parameter int                      CTL_W           = 8,
  parameter int                      SYNC_STAGES     = 2,
  parameter int                      BOOT_WINDOW     = 10,
  parameter int                      SRAM_LOG2       = 13,
  parameter int                      BOOT_ALIAS_LOG2 = 20,
  parameter logic [31:0]             SRAM_BOOT_BASE  = 32'h0030_0000,
  parameter logic [31:0]             EXT_BASE        = 32'h0040_0000,
  parameter logic [31:0]             PERIPH_BASE     = 32'hFFC0_0000,
  parameter logic [NUM_CS-1:0][31:0] CS_BASE         = {32'h0800_0000, 32'h0700_0000,
                                                        32'h0600_0000, 32'h0500_0000,
                                                        32'h0400_0000, 32'h0300_0000,
                                                        32'h0200_0000, 32'h0100_0000},
  parameter logic [NUM_CS-1:0][4:0]  CS_SIZE_LOG2    = {NUM_CS{5'd20}},
  parameter logic [NUM_CS-1:0]       CS_ENABLE       = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_pin,
  input  logic [31:0]       addr,
  input  logic              addr_vld,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic              sel_sram,
  output logic              sel_periph,
  output logic [NUM_CS-1:0] cs,
  output logic              boot_narrow,
  output logic              abort
);
  localparam logic [31:0] SRAM_BOOT_PAGE = SRAM_BOOT_BASE >> SRAM_LOG2;

  logic              remap;
  space_e            space;
  logic              in_ext;
  logic [NUM_CS-1:0] cs_hit;
  logic              alias_hit;
  logic              sram_hit;

  mmd_boot_sampler #(.SYNC_STAGES(SYNC_STAGES), .WINDOW(BOOT_WINDOW)) u_boot (
    .clk(clk), .rst_n(rst_n), .pin(boot_pin), .boot_narrow(boot_narrow));

  mmd_remap_reg #(.CTL_W(CTL_W)) u_remap (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata), .remap(remap));

  assign space  = classify(addr, EXT_BASE, PERIPH_BASE);
  assign in_ext = (space == SPACE_EXTERNAL);

  mmd_cs_match #(.NUM_CS(NUM_CS), .CS_BASE(CS_BASE), .CS_SIZE_LOG2(CS_SIZE_LOG2),
                 .CS_ENABLE(CS_ENABLE)) u_match (
    .addr(addr), .in_ext(in_ext), .remap(remap), .hit(cs_hit));

  always_comb begin
    alias_hit = 1'b0;
    sram_hit  = 1'b0;
    if (space == SPACE_INTERNAL) begin
      if (remap) begin
        sram_hit = ((addr >> SRAM_LOG2) == 32'd0);
      end else begin
        alias_hit = ((addr >> BOOT_ALIAS_LOG2) == 32'd0);
        sram_hit  = ((addr >> SRAM_LOG2) == SRAM_BOOT_PAGE);
      end
    end
  end

  always_comb begin
    cs         = '0;
    sel_sram   = 1'b0;
    sel_periph = 1'b0;
    abort      = 1'b0;
    if (addr_vld) begin
      cs         = cs_hit;
      cs[0]      = cs_hit[0] | alias_hit;
      sel_sram   = sram_hit;
      sel_periph = (space == SPACE_PERIPH);
      abort      = in_ext && (cs_hit == '0);
    end
  end

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_vld |-> (cs == '0 && !sel_sram && !sel_periph && !abort)); // R9
  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({abort, sel_periph, sel_sram, cs})); // R10
  AST_ABORT_EXT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (addr >= EXT_BASE && addr < PERIPH_BASE)); // R8
  AST_HIGH_CS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !remap |-> (cs[NUM_CS-1:1] == '0)); // R6
  AST_ALIAS_GONE: assert property (@(posedge clk) disable iff (!rst_n)
    (remap && addr_vld && addr < EXT_BASE) |-> !cs[0]); // R3
endmodule

// File: tb/tb_mem_map_decoder.sv
module tb_mem_map_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        boot_pin;
  logic [31:0] addr;
  logic        addr_vld;
  logic        ctl_wr;
  logic [7:0]  ctl_wdata;
  logic        sel_sram, sel_periph, boot_narrow, abort;
  logic [7:0]  cs;

  int checks = 0;
  int errors = 0;
  logic multi_seen = 1'b0;

  always #2 clk = ~clk;

  mem_map_decoder dut (
    .clk(clk), .rst_n(rst_n), .boot_pin(boot_pin), .addr(addr), .addr_vld(addr_vld),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .sel_sram(sel_sram), .sel_periph(sel_periph),
    .cs(cs), .boot_narrow(boot_narrow), .abort(abort));

  // {abort, periph, sram, cs[7:0]}
  function automatic logic [10:0] model(input logic [31:0] a, input logic rm, input logic vld);
    logic [10:0] e;
    int idx;
    e = '0;
    if (!vld) return e;
    if (a >= 32'hFFC0_0000) e[9] = 1'b1;
    else if (a < 32'h0040_0000) begin
      if (rm) e[8] = (a < 32'h2000);
      else begin
        if (a < 32'h0010_0000) e[0] = 1'b1;
        if (a >= 32'h0030_0000 && a < 32'h0030_2000) e[8] = 1'b1;
      end
    end else begin
      idx = int'(a >> 24);
      if (a[23:20] == 4'd0 && idx >= 1 && idx <= 8 && (idx == 1 || rm)) e[idx-1] = 1'b1;
      else e[10] = 1'b1;
    end
    return e;
  endfunction

  function automatic string tag(input logic [31:0] a, input logic rm);
    if (a >= 32'hFFC0_0000) return "R8";
    if (a < 32'h0040_0000) return rm ? "R3" : "R2";
    if (a[23:20] == 4'd0 && a[31:24] >= 8'd2 && a[31:24] <= 8'd8) return rm ? "R7" : "R6";
    if (a[23:20] == 4'd0 && a[31:24] == 8'd1) return "R7";
    return "R8";
  endfunction

  task automatic check(input logic [10:0] got, input logic [10:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h expected=%h addr=%h", req, got, exp, addr);
    end
  endtask

  function automatic logic [10:0] outs();
    return {abort, sel_periph, sel_sram, cs};
  endfunction

  task automatic probe(input logic [31:0] a, input logic rm, input string req);
    @(negedge clk);
    addr = a; addr_vld = 1'b1;
    #1;
    check(outs(), model(a, rm, 1'b1), req);
  endtask

  task automatic sweep(input logic rm);
    logic [31:0] offs [4] = '{32'h0, 32'h1FFF, 32'h2000, 32'hF_FFFF};
    for (int mb = 0; mb < 4096; mb++) begin
      for (int j = 0; j < 4; j++) begin
        @(negedge clk);
        addr = {mb[11:0], 20'h0} + offs[j];
        addr_vld = 1'b1;
        #1;
        if ($countones(outs()) > 1) multi_seen = 1'b1;
        check(outs(), model(addr, rm, 1'b1), tag(addr, rm));
      end
      if (mb % 256 == 0) begin
        @(negedge clk);
        addr_vld = 1'b0;
        #1;
        check(outs(), 11'd0, "R9");
      end
    end
    checks++;
    if (multi_seen) begin
      errors++;
      $display("FAIL R10 got=multiple targets expected=at most one");
    end
  endtask

  task automatic ctl_write(input logic [7:0] d);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_wdata = 8'h00;
  endtask

  task automatic do_reset(input logic pin);
    @(negedge clk);
    rst_n = 1'b0; boot_pin = pin; addr_vld = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b1;
    boot_pin = ~pin;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; boot_pin = 1'b1; addr = '0; addr_vld = 1'b0;
    ctl_wr = 1'b0; ctl_wdata = '0;
    do_reset(1'b1);
    #1;
    checks++;
    if (boot_narrow !== 1'b1) begin
      errors++; $display("FAIL R1 got=%b expected=1", boot_narrow);
    end
    check(outs(), 11'd0, "R9");
    probe(32'h0, 1'b0, "R2");

    sweep(1'b0);

    ctl_write(8'hFE);                      // bit 0 low: no remap (R4)
    probe(32'h0, 1'b0, "R4");
    probe(32'h0200_0000, 1'b0, "R4");

    ctl_write(8'h01);                      // sets remap (R4)
    probe(32'h0, 1'b1, "R4");
    multi_seen = 1'b0;
    sweep(1'b1);

    ctl_write(8'h00);                      // sticky (R4)
    probe(32'h0, 1'b1, "R4");
    probe(32'h0800_0000, 1'b1, "R7");

    do_reset(1'b0);                        // clears remap (R5), new strap (R1)
    #1;
    checks++;
    if (boot_narrow !== 1'b0) begin
      errors++; $display("FAIL R1 got=%b expected=0", boot_narrow);
    end
    probe(32'h0, 1'b0, "R5");
    probe(32'h0000_1000, 1'b0, "R5");
    probe(32'h0200_0000, 1'b0, "R6");
    repeat (20) @(negedge clk);
    checks++;
    if (boot_narrow !== 1'b0) begin
      errors++; $display("FAIL R1 got=%b expected=0 after pin change", boot_narrow);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog got=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule